// File: doc/BRIEF.md
# Pulse-Swallow Divider Sequencer

This block sits behind a dual-modulus prescaler that divides by P or P+1. It is clocked by the prescaler's output. From two programmed values it drives the prescaler's modulus-select line and emits one output pulse per complete division cycle. The programmed values are a 6-bit swallow count and a 12-bit main count.

Each division cycle lasts exactly N prescaler output clocks. During the first A of those clocks the modulus-select line asks for P+1. During the rest it asks for P. Referred to the prescaler input, the cycle therefore spans P·N + A input clocks. The programmed values are sampled only when a cycle begins. A value that is written mid-cycle waits for the next boundary.

Top module: `swallow_div_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) starts a fresh cycle at position 0, using the swallow and main counts present at that edge. In the first cycle after reset, div_pulse is 0, and mod_sel is 1 exactly when the swallow count is non-zero.
- R2: div_pulse is 1 for exactly one clock, the last of the N clocks in a cycle. Position 0 of the next cycle follows immediately after it.
- R3: mod_sel is 1 (request P+1) at cycle positions 0 through A-1 and 0 (request P) at the remaining positions. Across one cycle it is high for exactly A clocks when A ≤ N.
- R4: When the swallow count is 0, mod_sel stays 0 for the whole cycle.
- R5: Changes to swallow_set or count_set between cycle boundaries do not change the length of the current cycle, its mod_sel pattern or its ratio_err value. They take effect from the next cycle.
- R6: When the latched swallow count exceeds the latched main count, ratio_err is 1 for that whole cycle, mod_sel stays 1 throughout, and the cycle still ends after N clocks. Otherwise, and when N ≥ 5, ratio_err is 0.
- R7: A main count below 5 is treated as 5 (cycle length 5), and ratio_err is 1 for that cycle.
- R8: count_set bit 0 and swallow_set bit 0 are the least significant bits, so each field is read as an unsigned binary number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset, forces a cycle start |
| swallow_set | input | 6 | Swallow count A (0..63) |
| count_set | input | 12 | Main count N (5..4095) |
| mod_sel | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| div_pulse | output | 1 | One-clock pulse on the last clock of each cycle |
| ratio_err | output | 1 | Latched count pair is invalid for this cycle |

## Verification
The cases that are hardest to reach are those where the inputs differ from the values latched for the current cycle. Changing the inputs at a boundary is too late, and reloading on every clock would hide the fault. To reach them, the stimulus rewrites both fields several clocks into a cycle, while the reference model keeps counting with the values it latched at the boundary. The invalid pairs (A greater than N, and N below the minimum) are also applied mid-cycle, so that the latched error flag is seen switching exactly at a boundary.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
    localparam int SW_W_DEF  = 6;
    localparam int CNT_W_DEF = 12;
    localparam int CNT_MIN   = 5;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } modulus_e;
endpackage

// File: rtl/swallow_div_decode.sv
module swallow_div_decode #(
    parameter int SW_W  = swallow_div_pkg::SW_W_DEF,
    parameter int CNT_W = swallow_div_pkg::CNT_W_DEF,
    parameter int N_MIN = swallow_div_pkg::CNT_MIN
) (
    input  logic [SW_W-1:0]  sw_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_last,
    output logic             bad_pair
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(N_MIN);
    logic [CNT_W-1:0] cnt_eff;
    logic             too_small;

    always_comb begin
        too_small = (cnt_in < MIN_V);
        cnt_eff   = too_small ? MIN_V : cnt_in;
        cnt_last  = cnt_eff - CNT_W'(1);
        bad_pair  = too_small || (CNT_W'(sw_in) > cnt_in);
    end
endmodule

// File: rtl/swallow_div_main_ctr.sv
module swallow_div_main_ctr #(
    parameter int CNT_W = swallow_div_pkg::CNT_W_DEF,
    parameter int N_MIN = swallow_div_pkg::CNT_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_last,
    output logic             at_end
);
    logic [CNT_W-1:0] remain_q;
    logic             reload;

    assign at_end = (remain_q == '0);
    assign reload = rst || at_end;

    always_ff @(posedge clk) begin
        if (reload) remain_q <= cnt_last;
        else        remain_q <= remain_q - CNT_W'(1);
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> remain_q == $past(remain_q) - CNT_W'(1));
    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        at_end |=> remain_q == $past(cnt_last));
    assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
        at_end |=> remain_q >= CNT_W'(N_MIN - 1));
endmodule

// File: rtl/swallow_div_swallow_ctr.sv
module swallow_div_swallow_ctr #(
    parameter int SW_W = swallow_div_pkg::SW_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [SW_W-1:0] sw_load,
    output swallow_div_pkg::modulus_e modulus
);
    import swallow_div_pkg::*;
    logic [SW_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (load)              left_q <= sw_load;
        else if (left_q != '0) left_q <= left_q - SW_W'(1);
    end

    assign modulus = (left_q != '0) ? MOD_PLUS1 : MOD_BASE;

    assert_low_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (modulus == MOD_BASE && !load) |=> modulus == MOD_BASE);
    assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (load && sw_load == '0) |=> modulus == MOD_BASE);
endmodule

// File: rtl/swallow_div_top.sv
module swallow_div_top #(
    parameter int SW_W  = swallow_div_pkg::SW_W_DEF,
    parameter int CNT_W = swallow_div_pkg::CNT_W_DEF,
    parameter int N_MIN = swallow_div_pkg::CNT_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW_W-1:0]  swallow_set,
    input  logic [CNT_W-1:0] count_set,
    output logic             mod_sel,
    output logic             div_pulse,
    output logic             ratio_err
);
    import swallow_div_pkg::*;

    logic [CNT_W-1:0] cnt_last;
    logic             bad_pair;
    logic             at_end;
    logic             load;
    logic             err_q;
    modulus_e         modulus;

    swallow_div_decode #(.SW_W(SW_W), .CNT_W(CNT_W), .N_MIN(N_MIN)) dec_i (
        .sw_in(swallow_set), .cnt_in(count_set),
        .cnt_last(cnt_last), .bad_pair(bad_pair));

    swallow_div_main_ctr #(.CNT_W(CNT_W), .N_MIN(N_MIN)) main_i (
        .clk(clk), .rst(rst), .cnt_last(cnt_last), .at_end(at_end));

    assign load = rst || at_end;

    swallow_div_swallow_ctr #(.SW_W(SW_W)) sw_i (
        .clk(clk), .rst(rst), .load(load), .sw_load(swallow_set),
        .modulus(modulus));

    always_ff @(posedge clk) begin
        if (load) err_q <= bad_pair;
    end

    assign mod_sel   = (modulus == MOD_PLUS1);
    assign div_pulse = at_end;
    assign ratio_err = err_q;

    assert_err_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> $stable(ratio_err));
    assert_over_R6: assert property (@(posedge clk) disable iff (rst)
        (load && CNT_W'(swallow_set) > count_set) |=> (ratio_err && mod_sel));
    assert_mod_end_R6: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && !ratio_err) |-> ($past(mod_sel) == mod_sel || !mod_sel));
endmodule

// File: tb/swallow_div_top_tb_top.sv
module swallow_div_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  swallow_set = '0;
    logic [11:0] count_set = 12'd8;
    logic        mod_sel, div_pulse, ratio_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit compare_on = 0;

    int pos = 0, ca = 0, cn = 0, ceff = 0;
    bit cerr = 0;

    always #10 clk = ~clk;

    swallow_div_top dut_i (
        .clk(clk), .rst(rst), .swallow_set(swallow_set), .count_set(count_set),
        .mod_sel(mod_sel), .div_pulse(div_pulse), .ratio_err(ratio_err));

    always @(posedge clk) begin
        if (rst || pos == ceff - 1) begin
            ca   = int'(swallow_set);
            cn   = int'(count_set);
            ceff = (cn < 5) ? 5 : cn;
            cerr = (cn < 5) || (ca > cn);
            pos  = 0;
        end else begin
            pos = pos + 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (pos=%0d A=%0d N=%0d)",
                     tag, act, exp, pos, ca, cn);
        end
    endtask

    task automatic compare();
        string mtag, ptag, etag;
        bit pending;
        pending = (int'(swallow_set) != ca) || (int'(count_set) != cn);
        if (cerr && ca > cn)  mtag = "R6 mod_sel";
        else if (ca == 0)     mtag = "R4 mod_sel";
        else if (pending)     mtag = "R5 mod_sel";
        else                  mtag = "R3 mod_sel";
        if (cn < 5)           ptag = "R7 div_pulse";
        else if (pending)     ptag = "R5 div_pulse";
        else if (cn > 63)     ptag = "R8 div_pulse";
        else                  ptag = "R2 div_pulse";
        etag = (cn < 5) ? "R7 ratio_err" : "R6 ratio_err";
        check(mtag, int'(mod_sel), (pos < ca) ? 1 : 0);
        check(ptag, int'(div_pulse), (pos == ceff - 1) ? 1 : 0);
        check(etag, int'(ratio_err), cerr ? 1 : 0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (compare_on) compare();
        end
    endtask

    initial begin
        swallow_set = 6'd2; count_set = 12'd8;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state one clock after release, still first cycle position 1
        check("R1 mod_sel", int'(mod_sel), 1);
        check("R1 div_pulse", int'(div_pulse), 0);
        check("R1 ratio_err", int'(ratio_err), 0);
        compare_on = 1;
        compare();
        run(30);
        swallow_set = 6'd3;  count_set = 12'd10; run(45);
        swallow_set = 6'd0;  count_set = 12'd7;  run(30);
        swallow_set = 6'd10; count_set = 12'd6;  run(25);
        swallow_set = 6'd1;  count_set = 12'd2;  run(20);
        swallow_set = 6'd0;  count_set = 12'd0;  run(12);
        swallow_set = 6'd4;  count_set = 12'd12; run(40);
        // R5: rewrite mid-cycle
        run(5);
        swallow_set = 6'd9;  count_set = 12'd20; run(3);
        swallow_set = 6'd30; count_set = 12'd9;  run(50);
        // R8: wide values, bit 0 is LSB
        swallow_set = 6'd63; count_set = 12'd4095; run(8300);
        swallow_set = 6'd33; count_set = 12'd129;  run(300);
        // reset mid-cycle restarts
        swallow_set = 6'd5; count_set = 12'd11; run(4);
        rst = 1'b1; run(2); rst = 1'b0;
        run(40);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule